// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase outputs of an incremental rotary or linear encoder into a 32-bit position count. Both encoder inputs are asynchronous to the core clock. They pass through synchronisers, and an edge detector compares each synchronised sample with the sample before it. A source decoder then turns those edges into a count strobe and a direction. Software chooses one of four ways to read the inputs: full quadrature (x4), pulse with a direction level, up-count only, or down-count only. An edge-rate bit doubles the resolution in the two single-direction modes.

The position register wraps between zero and a software-set maximum. A separate floor register holds an initial value for software to use. All settings sit behind a small synchronous register port: write strobe, byte address, write data, and read data driven combinationally from the address. In quadrature mode, a sample where both phases change at once cannot be decoded. The block then drops the count and raises a sticky error output.

Top module: `qenc_pos_counter`

## Requirements
- R1: After reset the position reads 0, the floor reads 0, the maximum reads 0xFFFFFFFF, both control registers read 0 (quadrature mode, counter disabled) and `phase_err` is 0.
- R2: Register byte offsets are 0x00 position, 0x04 floor, 0x08 maximum, 0x28 decoder control and 0x2A main control. In decoder control, bits 15:14 select the source (0 quadrature, 1 pulse-direction, 2 up, 3 down) and bit 11 is the edge-rate bit. In main control, bit 3 is the counter enable. Bits not defined read as 0.
- R3: In quadrature mode, each single edge of A or B moves the count by one. The count goes up when A leads B (00→10→11→01→00 in AB order) and down in the reverse order.
- R4: In quadrature mode, a synchronised sample in which A and B both change causes no count and sets `phase_err`. `phase_err` stays at 1 until reset.
- R5: In pulse-direction mode, only rising edges of A count. The count goes up when B is high and down when B is low. Falling edges of A do not count.
- R6: In up mode the count goes up by one per A edge, and in down mode it goes down by one per A edge. With the edge-rate bit clear only rising A edges count; with it set both edges count. In both modes B has no effect.
- R7: While the enable bit is 0 the position holds, whatever the inputs do.
- R8: Counting up from a value at or above the maximum gives 0. Counting down from 0 gives the maximum.
- R9: A position write of a value not above the maximum is seen on the next clock. It wins over a count event in the same cycle.
- R10: A position write of a value above the current maximum is ignored.
- R11: An input change reaches the position on the third rising clock edge after the change. It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (16-bit registers take the low half) |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| phase_err | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest case to reach from the ports is a position write and a count event landing on the same clock edge. The count strobe appears three register stages after an encoder edge, so it cannot be seen directly. The bench changes A on a falling edge, waits exactly two cycles, and then raises the write strobe so that it is sampled on the edge where the decoded count would take effect. Wrap at both ends is reached by lowering the maximum to a small value, so random quadrature walks cross it often. The random walks include simultaneous A/B changes to trigger the phase error.

// File: rtl/qenc_pkg.sv
// Package: shared types and constants for the quadrature encoder position counter.
// Assumes: the source select code values are fixed by the register layout.
package qenc_pkg;

    typedef enum logic [1:0] {
        SRC_QUAD   = 2'd0,
        SRC_PULDIR = 2'd1,
        SRC_UP     = 2'd2,
        SRC_DOWN   = 2'd3
    } src_mode_e;

    localparam int DECCTL_SRC_LO   = 14;
    localparam int DECCTL_RATE_BIT = 11;
    localparam int MAINCTL_EN_BIT  = 3;

endpackage

// File: rtl/qenc_input_sync.sv
// Module: qenc_input_sync
// Puts each asynchronous input channel through a STAGES-deep flop chain.
// Flags an edge whenever the synchronised level differs from the previous one.
// Assumes: input pulses last longer than one clock period.
module qenc_input_sync #(
    parameter int NCH    = 2,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw,
    output logic [NCH-1:0] level,
    output logic [NCH-1:0] edge_seen
);

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            logic [STAGES-1:0] pipe;
            logic              last;

            // Shift the raw input through the synchroniser and keep the previous level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe <= '0;
                    last <= 1'b0;
                end else begin
                    pipe <= {pipe[STAGES-2:0], raw[ch]};
                    last <= pipe[STAGES-1];
                end
            end

            assign level[ch]     = pipe[STAGES-1];
            assign edge_seen[ch] = pipe[STAGES-1] ^ last;
        end
    endgenerate

endmodule

// File: rtl/qenc_source_decode.sv
// Module: qenc_source_decode
// Turns synchronised A/B levels and edges into a count strobe and direction,
// using the selected source mode. In quadrature mode it also reports an
// illegal step where both phases changed together.
// Assumes: the levels are the values after the edges shown.
module qenc_source_decode
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  src_mode_e mode,
    input  logic      both_edges,
    input  logic      lvl_a,
    input  logic      lvl_b,
    input  logic      edge_a,
    input  logic      edge_b,
    output logic      cnt_ev,
    output logic      cnt_up,
    output logic      illegal
);

    // Decode the count event and direction for the current mode.
    always_comb begin
        cnt_ev  = 1'b0;
        cnt_up  = 1'b1;
        illegal = 1'b0;
        unique case (mode)
            SRC_QUAD: begin
                if (edge_a && edge_b) begin
                    illegal = 1'b1;
                end else if (edge_a) begin
                    cnt_ev = 1'b1;
                    cnt_up = lvl_a ^ lvl_b;
                end else if (edge_b) begin
                    cnt_ev = 1'b1;
                    cnt_up = ~(lvl_a ^ lvl_b);
                end
            end
            SRC_PULDIR: begin
                cnt_ev = edge_a && lvl_a;
                cnt_up = lvl_b;
            end
            SRC_UP: begin
                cnt_ev = edge_a && (lvl_a || both_edges);
                cnt_up = 1'b1;
            end
            SRC_DOWN: begin
                cnt_ev = edge_a && (lvl_a || both_edges);
                cnt_up = 1'b0;
            end
            default: ;
        endcase
    end

    // R6: in the single-direction modes a count needs an edge on A.
    assert_updown_needs_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == SRC_UP || mode == SRC_DOWN) && !edge_a) |-> !cnt_ev);

    // R4: a step where both phases change never counts in quadrature mode.
    assert_illegal_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_QUAD && edge_a && edge_b) |-> (!cnt_ev && illegal));

endmodule

// File: rtl/qenc_pos_track.sv
// Module: qenc_pos_track
// Holds the position register. It wraps between zero and the maximum, and a
// software write of a value within range takes priority over counting.
// Assumes: max_val is stable register state.
module qenc_pos_track #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         cnt_ev,
    input  logic         cnt_up,
    input  logic [W-1:0] max_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] pos
);

    logic wr_ok;
    assign wr_ok = wr_en && (wr_val <= max_val);

    // Update the position: accepted write first, then an enabled count with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (wr_ok) begin
            pos <= wr_val;
        end else if (enable && cnt_ev) begin
            if (cnt_up) pos <= (pos >= max_val) ? '0 : pos + 1'b1;
            else        pos <= (pos == '0) ? max_val : pos - 1'b1;
        end
    end

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val <= max_val) |=> (pos == $past(wr_val)));

    assert_write_over_max_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val > max_val && !(enable && cnt_ev)) |=> $stable(pos));

    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !wr_en) |=> $stable(pos));

    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && enable && cnt_ev && cnt_up && pos >= max_val) |=> (pos == '0));

    assert_wrap_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && enable && cnt_ev && !cnt_up && pos == '0) |=> (pos == $past(max_val)));

endmodule

// File: rtl/qenc_pos_counter.sv
// Module: qenc_pos_counter (top)
// Quadrature encoder position counter with a small synchronous register port.
// Assumes: reg_rdata is decoded combinationally from reg_addr; writes land on
// the clock edge where reg_wr is sampled high.
module qenc_pos_counter
    import qenc_pkg::*;
#(
    parameter int POS_W  = 32,
    parameter int ADDR_W = 6,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              phase_err
);

    localparam logic [ADDR_W-1:0] OFS_POS   = ADDR_W'(6'h00);
    localparam logic [ADDR_W-1:0] OFS_FLOOR = ADDR_W'(6'h04);
    localparam logic [ADDR_W-1:0] OFS_MAX   = ADDR_W'(6'h08);
    localparam logic [ADDR_W-1:0] OFS_DEC   = ADDR_W'(6'h28);
    localparam logic [ADDR_W-1:0] OFS_MAIN  = ADDR_W'(6'h2A);

    logic [POS_W-1:0] floor_q, max_q, pos;
    src_mode_e        mode_q;
    logic             rate_q, en_q;
    logic [1:0]       lvl, edg;
    logic             cnt_ev, cnt_up, illegal;

    // Software-visible settings registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            floor_q <= '0;
            max_q   <= '1;
            mode_q  <= SRC_QUAD;
            rate_q  <= 1'b0;
            en_q    <= 1'b0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                OFS_FLOOR: floor_q <= reg_wdata[POS_W-1:0];
                OFS_MAX:   max_q   <= reg_wdata[POS_W-1:0];
                OFS_DEC: begin
                    mode_q <= src_mode_e'(reg_wdata[DECCTL_SRC_LO +: 2]);
                    rate_q <= reg_wdata[DECCTL_RATE_BIT];
                end
                OFS_MAIN:  en_q <= reg_wdata[MAINCTL_EN_BIT];
                default: ;
            endcase
        end
    end

    // Read mux; undefined bits and offsets read as zero.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_POS:   reg_rdata = 32'(pos);
            OFS_FLOOR: reg_rdata = 32'(floor_q);
            OFS_MAX:   reg_rdata = 32'(max_q);
            OFS_DEC: begin
                reg_rdata[DECCTL_SRC_LO +: 2]  = mode_q;
                reg_rdata[DECCTL_RATE_BIT]     = rate_q;
            end
            OFS_MAIN:  reg_rdata[MAINCTL_EN_BIT] = en_q;
            default: ;
        endcase
    end

    // Sticky phase error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_err <= 1'b0;
        else if (illegal) phase_err <= 1'b1;
    end

    qenc_input_sync #(.NCH(2), .STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       ({enc_b, enc_a}),
        .level     (lvl),
        .edge_seen (edg)
    );

    qenc_source_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .both_edges (rate_q),
        .lvl_a      (lvl[0]),
        .lvl_b      (lvl[1]),
        .edge_a     (edg[0]),
        .edge_b     (edg[1]),
        .cnt_ev     (cnt_ev),
        .cnt_up     (cnt_up),
        .illegal    (illegal)
    );

    qenc_pos_track #(.W(POS_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (en_q),
        .cnt_ev  (cnt_ev),
        .cnt_up  (cnt_up),
        .max_val (max_q),
        .wr_en   (reg_wr && reg_addr == OFS_POS),
        .wr_val  (reg_wdata[POS_W-1:0]),
        .pos     (pos)
    );

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |=> phase_err);

endmodule

// File: tb/qenc_pos_counter_tb.sv
module qenc_pos_counter_tb;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        enc_a = 0, enc_b = 0;
    logic [5:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        phase_err;

    int n_run = 0, n_fail = 0;

    // model state
    logic [31:0] m_pos = 0, m_max = 32'hFFFF_FFFF;
    logic [1:0]  m_mode = 0;
    bit          m_rate = 0, m_en = 0, m_err = 0;
    bit          pa = 0, pb = 0;

    always #10 clk = ~clk;

    qenc_pos_counter u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .phase_err(phase_err)
    );

    function automatic int step_delta(logic [1:0] md, bit eb, bit a0, bit b0,
                                      bit a1, bit b1, output bit ill);
        bit ac = a0 != a1;
        bit bc = b0 != b1;
        ill = 0;
        case (md)
            2'd0: begin
                if (ac && bc) begin ill = 1; return 0; end
                if (ac) return (a1 != b1) ? 1 : -1;
                if (bc) return (a1 == b1) ? 1 : -1;
                return 0;
            end
            2'd1: return (!a0 && a1) ? (b1 ? 1 : -1) : 0;
            2'd2: return (ac && (a1 || eb)) ? 1 : 0;
            default: return (ac && (a1 || eb)) ? -1 : 0;
        endcase
    endfunction

    function automatic logic [31:0] wrap_step(logic [31:0] p, logic [31:0] mx, int d);
        if (d > 0) return (p >= mx) ? 32'd0 : p + 1;
        if (d < 0) return (p == 0) ? mx : p - 1;
        return p;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic set_dec(logic [1:0] md, bit eb);
        wr(6'h28, (32'(md) << 14) | (32'(eb) << 11));
        m_mode = md; m_rate = eb;
    endtask

    task automatic set_en(bit e);
        wr(6'h2A, 32'(e) << 3);
        m_en = e;
    endtask

    task automatic step(bit a, bit b, string req);
        logic [31:0] d;
        bit ill;
        int dl;
        enc_a = a; enc_b = b;
        repeat (4) @(negedge clk);
        dl = step_delta(m_mode, m_rate, pa, pb, a, b, ill);
        if (ill) m_err = 1;
        if (m_en) m_pos = wrap_step(m_pos, m_max, dl);
        pa = a; pb = b;
        rd(6'h00, d);
        check(req, d, m_pos);
        check(req, 32'(phase_err), 32'(m_err));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(6'h00, d); check("R1 pos", d, 0);
        rd(6'h04, d); check("R1 floor", d, 0);
        rd(6'h08, d); check("R1 max", d, 32'hFFFF_FFFF);
        rd(6'h28, d); check("R1 decctl", d, 0);
        rd(6'h2A, d); check("R1 mainctl", d, 0);
        check("R1 err", 32'(phase_err), 0);

        // R2 register map
        wr(6'h04, 32'h1234_5678);
        rd(6'h04, d); check("R2 floor", d, 32'h1234_5678);
        wr(6'h08, 32'd9); m_max = 9;
        rd(6'h08, d); check("R2 max", d, 9);
        wr(6'h28, 32'hFFFF_FFFF);
        rd(6'h28, d); check("R2 decctl bits", d, 32'h0000_C800);
        set_dec(2'd0, 0);
        wr(6'h2A, 32'hFFFF_FFFF);
        rd(6'h2A, d); check("R2 mainctl bits", d, 32'h8);
        m_en = 1;

        // R11 latency: A rises, counts up on third edge
        enc_a = 1;
        @(negedge clk); @(negedge clk);
        rd(6'h00, d); check("R11 not after 2 edges", d, 0);
        @(negedge clk);
        rd(6'h00, d); check("R11 after 3 edges", d, 1);
        m_pos = 1; pa = 1; pb = 0;
        @(negedge clk);

        // R3 forward then reverse quadrature
        step(1, 1, "R3 up"); step(0, 1, "R3 up"); step(0, 0, "R3 up");
        step(0, 1, "R3 down"); step(1, 1, "R3 down"); step(1, 0, "R3 down");
        step(0, 0, "R3 down"); step(0, 1, "R8 wrap down"); step(1, 1, "R3 down");
        // R8 up wrap: walk up from 8 past 9
        step(0, 1, "R8 up"); step(0, 0, "R8 wrap up");
        // R4 illegal
        step(1, 1, "R4 illegal no count");
        step(0, 0, "R4 illegal again");
        step(1, 0, "R4 sticky after legal");

        // R7 disable holds
        set_en(0);
        step(1, 1, "R7 hold"); step(0, 1, "R7 hold"); step(0, 0, "R7 hold");
        set_en(1);

        // R5 pulse-direction
        set_dec(2'd1, 0);
        step(0, 1, "R5 b change no count");
        step(1, 1, "R5 rise up"); step(0, 1, "R5 fall none");
        step(0, 0, "R5 b low"); step(1, 0, "R5 rise down");
        step(0, 0, "R5 fall none");

        // R6 up/down, both rates, B ignored
        set_dec(2'd2, 0);
        step(1, 0, "R6 up rise"); step(0, 0, "R6 up fall none");
        step(0, 1, "R6 b ignored"); step(0, 0, "R6 b ignored");
        set_dec(2'd2, 1);
        step(1, 0, "R6 up x2 rise"); step(0, 0, "R6 up x2 fall");
        set_dec(2'd3, 0);
        step(1, 0, "R6 down rise"); step(0, 0, "R6 down fall none");
        step(0, 1, "R6 down b ignored");
        set_dec(2'd3, 1);
        step(1, 1, "R6 down x2 rise"); step(0, 1, "R6 down x2 fall");

        // R10 write above max ignored, R9 write accepted
        wr(6'h00, 32'd20);
        rd(6'h00, d); check("R10 over max ignored", d, m_pos);
        wr(6'h00, 32'd5); m_pos = 5;
        rd(6'h00, d); check("R9 write next clock", d, 5);

        // R9 write and count on the same edge (mode down x2, A edge)
        enc_a = 1;
        @(negedge clk); @(negedge clk);
        wr(6'h00, 32'd7);
        pa = 1;
        rd(6'h00, d); check("R9 write beats count", d, 7);
        m_pos = 7;
        repeat (3) @(negedge clk);
        rd(6'h00, d); check("R9 no late count", d, 7);

        // random walk
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 16) == 0) set_dec(2'($urandom % 4), bit'($urandom % 2));
            if (($urandom % 32) == 0) set_en(bit'(($urandom % 4) != 0));
            if (($urandom % 40) == 0) begin
                logic [31:0] v = $urandom % 14;
                wr(6'h00, v);
                if (v <= m_max) m_pos = v;
                rd(6'h00, d); check("R9/R10 random write", d, m_pos);
            end
            if (m_mode == 0 && ($urandom % 8) != 0) begin
                if ($urandom % 2) step(~pa, pb, "R3 random");
                else              step(pa, ~pb, "R3 random");
            end else begin
                step(bit'($urandom % 2), bit'($urandom % 2), "R4/R5/R6 random");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule